// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines and reduces them to a single interrupt output for a processor. Each source has a fixed rank set by its index, with index 0 the most urgent. It also has its own vector address, so the processor can branch straight to that source's handler without polling the sources one by one. While the interrupt output is high, the vector of the chosen source is on the vector output.

The processor accepts the offered source with an acknowledge pulse. That pulse moves the source from the pending set into the in-service set. An end-of-service pulse retires the most urgent level still in service. A mode input selects how requests that arrive during service are treated. In nesting mode, a source more urgent than every level in service can preempt, and less urgent work waits until the higher levels have retired. In serial mode nothing is offered while any level is in service. A mask register hides sources from selection but keeps their pending state.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), irq and vec_out are 0, and no source is pending, in service or masked.
- R2: A request held high for one cycle is remembered as pending. At the same clock edge, irq goes high and vec_out shows that source's vector, which is taken from vec_tbl bits [i*VEC_W +: VEC_W] for source i.
- R3: When several eligible sources are pending at once, the one with the lowest index is offered.
- R4: Whenever irq is low, vec_out is 0.
- R5: An ack sampled while irq is high clears the offered source's pending bit and sets its in-service bit. An ack sampled while irq is low changes nothing.
- R6: With nest_mode=1, a pending source is eligible only if its index is below the lowest index in service. Such a source raises irq while other levels are in service. A source at or above that index does not raise irq.
- R7: An eos pulse clears the lowest-index in-service bit. Less urgent pending work is offered once no more urgent level remains in service.
- R8: With nest_mode=0, irq stays low while any level is in service. Requests that arrive in that time stay pending and are offered after eos empties the in-service set.
- R9: mask_wr=1 loads mask_data into the mask, where a 1 bit blocks that source. A masked source is never offered, but its pending bit is kept, so it is offered once it is unmasked.
- R10: When ack and eos come in the same cycle, eos retires the lowest in-service bit held before that edge, and ack then adds the offered source.
- R11: irq and vec_out are registered. They reflect the pending, in-service and mask state written at the same clock edge, so a stale selection is never offered after an ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NSRC | Request lines, index 0 most urgent |
| vec_tbl | input | NSRC*VEC_W | Per-source vector addresses, packed by index |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | NSRC | New mask value, 1 blocks a source |
| nest_mode | input | 1 | 1 = nesting preemption, 0 = serial service |
| ack | input | 1 | Processor accepts the offered source |
| eos | input | 1 | Processor finished the current level |
| irq | output | 1 | Interrupt to the processor |
| vec_out | output | VEC_W | Vector of the offered source, 0 when idle |

## Verification
Acknowledge and end-of-service can land on the same edge. The outcome there depends on eos acting on the in-service set held before the edge, while ack adds the newly offered level. The bench provokes this with one level in service and a more urgent one offered, then pulses both together. It judges the result from irq staying low, because the new level blocks the waiting lower ones. A later single eos must then bring back the lower-priority pending source, which shows that exactly one level remained in service.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_NEST   = 1'b1
  } mode_e;
endpackage

// File: rtl/nic_first_set.sv
module nic_first_set #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits,
  output logic [N-1:0] onehot,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | bits[i];
    assign onehot[i]  = bits[i] & ~seen[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/nic_elig.sv
module nic_elig #(
  parameter int N = 8
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] isr,
  input  logic [N-1:0] mask,
  input  logic         nest,
  output logic [N-1:0] elig
);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] isr_oh;
  logic         isr_any;
  logic [N-1:0] blocked;

  nic_first_set #(.N(N)) i_isr_low (
    .bits   (isr),
    .onehot (isr_oh),
    .any    (isr_any)
  );

  // bits at or above the lowest in-service index; none when idle
  always_comb begin
    if (nest) blocked = ~(isr_oh - ONE) & {N{isr_any}};
    else      blocked = {N{isr_any}};
  end

  assign elig = pend & ~mask & ~blocked;
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*VEC_W-1:0] vec_tbl,
  input  logic                  mask_wr,
  input  logic [NSRC-1:0]       mask_data,
  input  logic                  nest_mode,
  input  logic                  ack,
  input  logic                  eos,
  output logic                  irq,
  output logic [VEC_W-1:0]      vec_out
);
  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  mode_e mode;
  assign mode = nest_mode ? MODE_NEST : MODE_SERIAL;

  logic [NSRC-1:0]  pend_q, isr_q, mask_q, sel_oh_q;
  logic [NSRC-1:0]  pend_d, isr_d, mask_d;
  logic [NSRC-1:0]  ack_set, eos_clr, isr_oh, elig_d, sel_oh_d;
  logic             isr_any, sel_any_d, irq_q;
  logic [VEC_W-1:0] vec_d, vec_q;

  nic_first_set #(.N(NSRC)) i_retire (
    .bits   (isr_q),
    .onehot (isr_oh),
    .any    (isr_any)
  );

  assign ack_set = (ack && irq_q) ? sel_oh_q : '0;
  assign eos_clr = (eos && isr_any) ? isr_oh : '0;
  assign isr_d   = (isr_q & ~eos_clr) | ack_set;
  assign pend_d  = (pend_q | req) & ~ack_set;
  assign mask_d  = mask_wr ? mask_data : mask_q;

  nic_elig #(.N(NSRC)) i_elig (
    .pend (pend_d),
    .isr  (isr_d),
    .mask (mask_d),
    .nest (mode == MODE_NEST),
    .elig (elig_d)
  );

  nic_first_set #(.N(NSRC)) i_pick (
    .bits   (elig_d),
    .onehot (sel_oh_d),
    .any    (sel_any_d)
  );

  always_comb begin
    vec_d = '0;
    for (int i = 0; i < NSRC; i++)
      if (sel_oh_d[i]) vec_d = vec_d | vec_tbl[i*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      isr_q    <= '0;
      mask_q   <= '0;
      sel_oh_q <= '0;
      irq_q    <= 1'b0;
      vec_q    <= '0;
    end else begin
      pend_q   <= pend_d;
      isr_q    <= isr_d;
      mask_q   <= mask_d;
      sel_oh_q <= sel_oh_d;
      irq_q    <= sel_any_d;
      vec_q    <= vec_d;
    end
  end

  assign irq     = irq_q;
  assign vec_out = vec_q;

  // R4: idle output carries no vector
  p_idle_vec_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> (vec_q == '0));

  // R3: exactly one source offered
  p_single_pick_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($countones(sel_oh_q) == 1));

  // R6: offered source is above every level in service
  p_above_service_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((isr_q & (sel_oh_q | (sel_oh_q - ONE))) == '0));

  // R9: masked source never offered
  p_mask_block_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((sel_oh_q & mask_q) == '0));

  // R5: accepted source enters service
  p_ack_enters_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_q) |=> ((isr_q & $past(sel_oh_q)) == $past(sel_oh_q)));

  // R8: serial mode offers nothing while a level stays in service
  p_serial_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!nest_mode && (isr_q != '0) && !eos) |=> !irq_q);
endmodule

// File: tb/test_nested_irq_ctrl.sv
module test_nested_irq_ctrl;
  localparam int NSRC  = 8;
  localparam int VEC_W = 8;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NSRC-1:0]       req;
  logic [NSRC*VEC_W-1:0] vec_tbl;
  logic                  mask_wr;
  logic [NSRC-1:0]       mask_data;
  logic                  nest_mode;
  logic                  ack;
  logic                  eos;
  logic                  irq;
  logic [VEC_W-1:0]      vec_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nested_irq_ctrl #(.NSRC(NSRC), .VEC_W(VEC_W)) i_nested_irq_ctrl (
    .clk(clk), .rst(rst), .req(req), .vec_tbl(vec_tbl),
    .mask_wr(mask_wr), .mask_data(mask_data), .nest_mode(nest_mode),
    .ack(ack), .eos(eos), .irq(irq), .vec_out(vec_out)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [7:0] req;
    logic       mwr;
    logic [7:0] mdat;
    logic       nest;
    logic       ack;
    logic       eos;
    logic       xirq;
    logic [7:0] xvec;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t STEPS [NSTEP] = '{
    '{4'd4,  8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 idle
    '{4'd2,  8'h20, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5}, // R2 pulse src5
    '{4'd11, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5}, // R11 held
    '{4'd3,  8'h48, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA3}, // R3 src3,6 vs 5
    '{4'd5,  8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R5 ack 3
    '{4'd6,  8'h02, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA1}, // R6 preempt src1
    '{4'd5,  8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R5 ack 1
    '{4'd6,  8'h04, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R6 src2 below 1
    '{4'd7,  8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA2}, // R7 eos 1
    '{4'd10, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R10 ack2+eos3
    '{4'd7,  8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5}, // R7 resume src5
    '{4'd9,  8'h00, 1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA6}, // R9 mask 5
    '{4'd9,  8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // R9 ack6, 5 masked
    '{4'd9,  8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5}, // R9 unmask
    '{4'd8,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R8 serial busy
    '{4'd8,  8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R8 src0 waits
    '{4'd5,  8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R5 ack ignored
    '{4'd8,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA0}, // R8 eos -> src0
    '{4'd8,  8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R8 ack0
    '{4'd8,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5}, // R8 eos -> src5
    '{4'd8,  8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R8 ack5
    '{4'd4,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}  // R4 all done
  };

  task automatic check(input int rq, input logic xirq, input logic [7:0] xvec);
    n_chk++;
    if (irq !== xirq || vec_out !== xvec) begin
      n_fail++;
      $display("FAIL R%0d: irq=%0b vec=%02h expected irq=%0b vec=%02h",
               rq, irq, vec_out, xirq, xvec);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NSRC; i++) vec_tbl[i*VEC_W +: VEC_W] = 8'hA0 + 8'(i);
    rst = 1'b1; req = '0; mask_wr = 1'b0; mask_data = '0;
    nest_mode = 1'b1; ack = 1'b0; eos = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(1, 1'b0, 8'h00);                         // R1 reset state

    for (int s = 0; s < NSTEP; s++) begin
      req       = STEPS[s].req;
      mask_wr   = STEPS[s].mwr;
      mask_data = STEPS[s].mdat;
      nest_mode = STEPS[s].nest;
      ack       = STEPS[s].ack;
      eos       = STEPS[s].eos;
      @(posedge clk);
      @(negedge clk);
      check(int'(STEPS[s].rq), STEPS[s].xirq, STEPS[s].xvec);
    end

    // R2 lowest-priority source still reaches the output
    req = 8'h80; mask_wr = 1'b0; nest_mode = 1'b1; ack = 1'b0; eos = 1'b0;
    @(posedge clk); @(negedge clk);
    req = '0;
    check(2, 1'b1, 8'hA7);

    // R1 reset in flight clears pending
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1, 1'b0, 8'h00);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, 1'b0, 8'h00);

    finish_run();
  end
endmodule